// File: doc/BRIEF.md
# Shared Lock Bank with Slotted Claim and Instant Release

This block holds a set of hardware locks that a group of cores use to coordinate with each other. A core can take a lock only when the rotating hub slot points at it. The slot moves forward by one core on every clock. While its slot is active, a core names one lock. One cycle later it gets an acknowledge, and a success flag that says whether it now holds that lock.

A core does not wait for its slot to release locks. In any cycle, any core can present a bitmask of locks to clear. The masks from all cores are OR-ed together, and every lock named in the combined mask is freed at the next clock edge. The registered lock vector goes to every core on every cycle.

Each core also gives a watch mask. Its release-event output goes high in the same cycle as a clear request that frees a lock the core watches and that is currently held. A waiting core is therefore woken without any hub-slot delay.

Top module: `hub_lock_bank`

## Requirements
- R1: After reset every lock is clear, the slot index is 0, and every acknowledge, success and release-event output is 0.
- R2: The slot index counts 0, 1, ..., NCORE-1 and then wraps to 0, advancing once per clock.
- R3: A claim request from a core whose slot is not active is ignored. It produces no acknowledge and changes no lock.
- R4: When the active-slot core requests lock L (claim_id bits [c*LW +: LW]), the next cycle shows claim_ack bit c high. If L was free after applying that cycle's clears, claim_ok bit c is also high and lock_state bit L is set.
- R5: A claim of a lock that is held and not being cleared in that cycle returns claim_ack high with claim_ok low, and the lock vector is unchanged.
- R6: The clear masks of all cores (core c uses clr_mask bits [c*NLOCK +: NLOCK], bit i meaning lock i) are OR-ed together. Every lock named in the combined mask reads 0 in lock_state after the next edge, regardless of the slot, unless R7 applies.
- R7: If a clear and the active claim name the same lock in one cycle, the clear is applied first. The claim then succeeds and the lock remains set.
- R8: rel_evt bit c is high, in the same cycle as the clear inputs, when the combined clear mask names a lock that is currently held and whose bit is set in watch_mask bits [c*NLOCK +: NLOCK].
- R9: rel_evt bit c stays low when the cleared locks were not held or are not in core c's watch mask.
- R10: lock_state always shows the full registered lock vector to all cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| claim_req | input | NCORE | Per-core claim request |
| claim_id | input | NCORE*LW | Per-core lock index to claim |
| clr_mask | input | NCORE*NLOCK | Per-core mask of locks to release |
| watch_mask | input | NCORE*NLOCK | Per-core mask of locks to watch |
| slot | output | CW | Core currently owning the hub slot |
| lock_state | output | NLOCK | Registered lock vector, 1 = held |
| claim_ack | output | NCORE | Claim answered (one cycle after request) |
| claim_ok | output | NCORE | Claim succeeded |
| rel_evt | output | NCORE | Same-cycle release of a watched held lock |

## Verification
An error in the stored lock vector shows on lock_state one edge after the faulty update. It also changes the claim_ok answer of the next core that claims that lock, and the rel_evt outputs of any core watching it. An error in the slot counter appears at once on the slot output. It also sends the acknowledge to the wrong core one cycle later. The bench compares every output on every cycle against a model, so each such fault is reported within one or two clocks. The release events are checked before the edge, which exposes any added register on that path.

// File: rtl/hub_lock_bank.sv
module hub_lock_bank #(
  parameter int NCORE = 16,
  parameter int NLOCK = 16,
  localparam int CW = $clog2(NCORE),
  localparam int LW = $clog2(NLOCK)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCORE-1:0]       claim_req,
  input  logic [NCORE*LW-1:0]    claim_id,
  input  logic [NCORE*NLOCK-1:0] clr_mask,
  input  logic [NCORE*NLOCK-1:0] watch_mask,
  output logic [CW-1:0]          slot,
  output logic [NLOCK-1:0]       lock_state,
  output logic [NCORE-1:0]       claim_ack,
  output logic [NCORE-1:0]       claim_ok,
  output logic [NCORE-1:0]       rel_evt
);

  logic [CW-1:0]    slot_q;
  logic [NLOCK-1:0] lock_q;
  logic [NLOCK-1:0] clr_any;
  logic [NLOCK-1:0] kept;
  logic [NLOCK-1:0] set_vec;
  logic [NCORE-1:0] ack_q, ok_q;
  logic [LW-1:0]    id_sel;
  logic             req_sel, grant;

  always_comb begin
    clr_any = '0;
    for (int c = 0; c < NCORE; c++)
      clr_any |= clr_mask[c*NLOCK +: NLOCK];
  end

  assign req_sel = claim_req[slot_q];
  assign id_sel  = claim_id[slot_q*LW +: LW];
  assign kept    = lock_q & ~clr_any;
  assign grant   = req_sel & ~kept[id_sel];
  assign set_vec = grant ? (NLOCK'(1) << id_sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      lock_q <= '0;
      ack_q  <= '0;
      ok_q   <= '0;
    end else begin
      slot_q <= (slot_q == CW'(NCORE-1)) ? '0 : slot_q + 1'b1;
      lock_q <= kept | set_vec;
      ack_q  <= req_sel ? (NCORE'(1) << slot_q) : '0;
      ok_q   <= grant ? (NCORE'(1) << slot_q) : '0;
    end
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_evt
    assign rel_evt[c] = |(watch_mask[c*NLOCK +: NLOCK] & lock_q & clr_any);
  end

  assign slot       = slot_q;
  assign lock_state = lock_q;
  assign claim_ack  = ack_q;
  assign claim_ok   = ok_q;

endmodule

// File: rtl/hub_lock_bank_chk.sv
module hub_lock_bank_chk #(
  parameter int NCORE = 16,
  parameter int NLOCK = 16,
  localparam int CW = $clog2(NCORE)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCORE*NLOCK-1:0] clr_mask,
  input logic [CW-1:0]          slot,
  input logic [NLOCK-1:0]       lock_state,
  input logic [NCORE-1:0]       claim_ack,
  input logic [NCORE-1:0]       claim_ok
);
  logic [NLOCK-1:0] clr_seen;
  always_comb begin
    clr_seen = '0;
    for (int c = 0; c < NCORE; c++)
      clr_seen |= clr_mask[c*NLOCK +: NLOCK];
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> slot == (($past(slot) == CW'(NCORE-1)) ? '0 : $past(slot) + 1'b1)); // R2
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_ack)); // R3
  AST_OK_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_ok & ~claim_ack) == '0); // R4
  AST_ONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_state & ~$past(lock_state)) <= 1); // R4
  AST_SET_NEEDS_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lock_state & ~$past(lock_state))) |-> (|claim_ok)); // R5
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !(|claim_ok) |-> (lock_state & $past(clr_seen)) == '0); // R6
endmodule

bind hub_lock_bank hub_lock_bank_chk #(.NCORE(NCORE), .NLOCK(NLOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_mask(clr_mask), .slot(slot),
  .lock_state(lock_state), .claim_ack(claim_ack), .claim_ok(claim_ok)
);

// File: tb/sim_hub_lock_bank.sv
module sim_hub_lock_bank;
  localparam int PERIOD = 10;
  localparam int NC = 16, NL = 16, CW = 4, LW = 4;

  logic clk = 0, rst_n = 0;
  logic [NC-1:0]    claim_req = '0;
  logic [NC*LW-1:0] claim_id = '0;
  logic [NC*NL-1:0] clr_mask = '0, watch_mask = '0;
  logic [CW-1:0] slot;
  logic [NL-1:0] lock_state;
  logic [NC-1:0] claim_ack, claim_ok, rel_evt;

  int n_chk = 0, n_bad = 0;
  logic [CW-1:0] m_slot;
  logic [NL-1:0] m_lock;
  logic [NC-1:0] m_ack, m_ok;

  always #(PERIOD/2) clk = ~clk;

  hub_lock_bank u0 (.*);

  function automatic logic [NL-1:0] f_clr(input logic [NC*NL-1:0] m);
    logic [NL-1:0] r = '0;
    for (int c = 0; c < NC; c++) r |= m[c*NL +: NL];
    return r;
  endfunction

  function automatic logic [NC-1:0] f_evt(input logic [NL-1:0] lk, input logic [NC*NL-1:0] cm,
                                          input logic [NC*NL-1:0] wm);
    logic [NC-1:0] r;
    logic [NL-1:0] cl = f_clr(cm);
    for (int c = 0; c < NC; c++) r[c] = |(wm[c*NL +: NL] & lk & cl);
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    logic [NL-1:0] cl, kept, nl;
    logic [LW-1:0] id;
    logic g;
    #1;
    check({tag, " R8/R9 rel_evt"}, 64'(rel_evt), 64'(f_evt(m_lock, clr_mask, watch_mask)));
    cl = f_clr(clr_mask);
    kept = m_lock & ~cl;
    id = claim_id[m_slot*LW +: LW];
    g = claim_req[m_slot] && !kept[id];
    nl = kept | (g ? (NL'(1) << id) : '0);
    m_ack = claim_req[m_slot] ? (NC'(1) << m_slot) : '0;
    m_ok = g ? (NC'(1) << m_slot) : '0;
    @(posedge clk); #1;
    m_lock = nl;
    m_slot = m_slot + 1'b1;
    check({tag, " R2 slot"}, 64'(slot), 64'(m_slot));
    check({tag, " R3/R4 ack"}, 64'(claim_ack), 64'(m_ack));
    check({tag, " R4/R5/R7 ok"}, 64'(claim_ok), 64'(m_ok));
    check({tag, " R6/R10 lock_state"}, 64'(lock_state), 64'(m_lock));
  endtask

  initial begin
    #(PERIOD*150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #2;
    check("R1 slot", 64'(slot), 0);
    check("R1 lock_state", 64'(lock_state), 0);
    check("R1 ack", 64'(claim_ack), 0);
    check("R1 ok", 64'(claim_ok), 0);
    check("R1 evt", 64'(rel_evt), 0);
    rst_n = 1;
    m_slot = 0; m_lock = '0;
    // R9: clearing locks that are not held gives no event
    watch_mask = '1; clr_mask = '0; clr_mask[5*NL +: NL] = 16'h00ff;
    step("R9 unheld");
    clr_mask = '0;
    // R4: every core claims its own lock number in its slot
    claim_req = '1;
    for (int c = 0; c < NC; c++) claim_id[c*LW +: LW] = LW'(c);
    for (int i = 0; i < NC; i++) step("R4 fill");
    check("R4 all held", 64'(lock_state), 64'(16'hffff));
    // R5: claims of held locks fail
    for (int i = 0; i < 4; i++) step("R5 held");
    // R7/R8: core 9 clears the lock being claimed; core 2 watches it
    for (int c = 0; c < NC; c++) claim_id[c*LW +: LW] = LW'(m_slot);
    watch_mask = '0; watch_mask[2*NL +: NL] = NL'(1) << m_slot;
    clr_mask[9*NL +: NL] = NL'(1) << m_slot;
    #1;
    check("R8 same-cycle evt", 64'(rel_evt), 64'(16'h0004));
    step("R7 clear+claim");
    // R9: unwatched core sees no event; R3: only slot owner counts
    clr_mask = '0; claim_req = '0; claim_req[(m_slot + 3) % NC] = 1'b1;
    step("R3 off-slot");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < NC; c++) begin
        claim_req[c] = ($urandom % 2) == 0;
        claim_id[c*LW +: LW] = LW'($urandom);
        clr_mask[c*NL +: NL] = (($urandom % 12) == 0) ? NL'($urandom) : '0;
        watch_mask[c*NL +: NL] = NL'($urandom);
      end
      step("RND");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule